// File: doc/BRIEF.md
# Microcode Bus Driver with Constant Masking

This block forms the 16-bit processor bus word for one microinstruction. A 3-bit source field picks one primary driver: the register file read port, a forced zero, the idle all-ones level, one of two task-specific inputs, or memory read data. Two further source codes stand for peripheral readers that are not fitted here, and they read as all ones.

A constant store sits beside the source mux. It holds 256 words and is addressed by the source field joined to the 5-bit register select. If either special-function field carries the constant code, the bus carries the stored word alone. If the source code is one of the three upper codes, the stored word is ANDed onto the selected source as a mask, so each upper source gets 32 mask words of its own. The bus acts as a wired AND of every enabled driver.

The block is purely combinational. The constant store is read asynchronously. Its contents come either from a flat parameter vector or from a built-in address pattern.

Top module: `mc_bus_driver`

## Requirements
- R1: Source code 0 with no constant function drives `reg_rdata` onto the bus.
- R2: Source code 1 with no constant function forces the bus to all zeros.
- R3: Source code 2 with no constant function leaves the bus at all ones (16'hFFFF).
- R4: Source codes 3 and 4 with no constant function drive `task_a_data` and `task_b_data` respectively.
- R5: The constant store address is `{bus_src, reg_sel}`, with the source field in bits 7:5 and the register select in bits 4:0.
- R6: When `fn1` equals 7, the bus equals the constant word at the R5 address, whatever the source code and data inputs.
- R7: When `fn2` equals 7, the bus equals the constant word at the R5 address, whatever the source code and data inputs.
- R8: Source code 5 with no constant function drives `mem_rdata` AND the constant word at the R5 address.
- R9: Source codes 6 and 7 with no constant function drive the constant word at the R5 address unchanged, because the unfitted reader is taken as all ones.
- R10: Special-function codes other than 7, in either field, have no effect on the bus.
- R11: With the default parameters, the constant word at address a is {a[7:0], ~a[7:0]}: the address in the upper byte and its complement in the lower byte.
- R12: The bus is a combinational function of the present inputs. No clock or state is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_rdata | input | 16 | Register file read data |
| mem_rdata | input | 16 | Memory read data |
| task_a_data | input | 16 | First task-specific source |
| task_b_data | input | 16 | Second task-specific source |
| bus_src | input | 3 | Bus source field |
| reg_sel | input | 5 | Register select field |
| fn1 | input | 4 | Special function 1 field |
| fn2 | input | 4 | Special function 2 field |
| bus_out | output | 16 | Resulting processor bus word |

## Verification
Every result is due in the same cycle as its stimulus, with zero register stages between the fields and `bus_out`. The driver applies a new instruction one time unit after each rising edge and queues the expected word. The monitor compares at the following falling edge, once the combinational path has settled and well before the next change of inputs. The sweep covers all eight source codes and all 32 register selects. Each pair is run with no function, with the constant code in either field or both, and with non-constant function codes, using data patterns that vary per step.

// File: rtl/mc_bus_pkg.sv
package mc_bus_pkg;

   localparam int unsigned SRC_W = 3;

   typedef enum logic [SRC_W-1:0] {
      SRC_REG    = 3'd0,
      SRC_ZERO   = 3'd1,
      SRC_IDLE   = 3'd2,
      SRC_TASK_A = 3'd3,
      SRC_TASK_B = 3'd4,
      SRC_MEM    = 3'd5,
      SRC_PERIPH0 = 3'd6,
      SRC_PERIPH1 = 3'd7
   } bus_src_e;

   // first source code that receives a constant mask
   localparam logic [SRC_W-1:0] MASK_SRC_FIRST = 3'd5;

   typedef struct packed {
      logic const_only;
      logic mask_en;
   } gate_ctl_t;

endpackage

// File: rtl/mc_const_store.sv
module mc_const_store #(
   parameter int unsigned DATA_W           = 16,
   parameter int unsigned ADDR_W           = 8,
   parameter bit          CONST_FROM_PARAM = 1'b0,
   parameter logic [(2**ADDR_W)*DATA_W-1:0] CONST_FLAT = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] word
);
   localparam int unsigned DEPTH = 2 ** ADDR_W;

   function automatic logic [DATA_W-1:0] pattern_word(input int unsigned a);
      logic [DATA_W-1:0] r;
      logic [ADDR_W-1:0] av;
      r  = '0;
      av = ADDR_W'(a);
      for (int i = 0; i < int'(ADDR_W); i++) begin
         if (i < int'(DATA_W)) r[i] = ~av[i];
         if (i + int'(ADDR_W) < int'(DATA_W)) r[i + int'(ADDR_W)] = av[i];
      end
      return r;
   endfunction

   logic [DATA_W-1:0] table_q [DEPTH];

   generate
      if (DATA_W < ADDR_W) begin : g_bad_width
         $error("mc_const_store: DATA_W must be at least ADDR_W");
      end
      for (genvar a = 0; a < int'(DEPTH); a++) begin : g_entry
         if (CONST_FROM_PARAM) begin : g_param
            assign table_q[a] = CONST_FLAT[a*DATA_W +: DATA_W];
         end else begin : g_pattern
            assign table_q[a] = pattern_word(a);
         end
      end
   endgenerate

   assign word = table_q[addr];

endmodule

// File: rtl/mc_src_select.sv
module mc_src_select
   import mc_bus_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [SRC_W-1:0]  bus_src,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] task_a_data,
   input  logic [DATA_W-1:0] task_b_data,
   output logic [DATA_W-1:0] src_word
);
   localparam logic [DATA_W-1:0] ALL_ONES = '1;

   always_comb begin
      unique case (bus_src_e'(bus_src))
         SRC_REG:     src_word = reg_rdata;
         SRC_ZERO:    src_word = '0;
         SRC_IDLE:    src_word = ALL_ONES;
         SRC_TASK_A:  src_word = task_a_data;
         SRC_TASK_B:  src_word = task_b_data;
         SRC_MEM:     src_word = mem_rdata;
         SRC_PERIPH0: src_word = ALL_ONES;
         SRC_PERIPH1: src_word = ALL_ONES;
         default:     src_word = ALL_ONES;
      endcase
   end

   // R2
   always_comb begin
      if (bus_src == SRC_ZERO) begin
         zero_src_chk: assert (src_word == '0)
            else $error("zero source not all zeros");
      end
   end

endmodule

// File: rtl/mc_gate_ctl.sv
module mc_gate_ctl
   import mc_bus_pkg::*;
#(
   parameter int unsigned FN_W          = 4,
   parameter int unsigned CONST_FN_CODE = 7
) (
   input  logic [SRC_W-1:0] bus_src,
   input  logic [FN_W-1:0]  fn1,
   input  logic [FN_W-1:0]  fn2,
   output gate_ctl_t        ctl
);
   localparam logic [FN_W-1:0] CONST_CODE = FN_W'(CONST_FN_CODE);

   generate
      if (CONST_FN_CODE >= (2 ** FN_W)) begin : g_bad_code
         $error("mc_gate_ctl: CONST_FN_CODE does not fit in FN_W");
      end
   endgenerate

   logic fn1_const, fn2_const, upper_src;

   assign fn1_const = (fn1 == CONST_CODE);
   assign fn2_const = (fn2 == CONST_CODE);
   assign upper_src = (bus_src >= MASK_SRC_FIRST);

   assign ctl.const_only = fn1_const | fn2_const;
   assign ctl.mask_en    = fn1_const | fn2_const | upper_src;

   // R6 R7
   always_comb begin
      if (ctl.const_only) begin
         const_implies_mask_chk: assert (ctl.mask_en)
            else $error("constant function without mask enable");
      end
   end

endmodule

// File: rtl/mc_bus_driver.sv
module mc_bus_driver
   import mc_bus_pkg::*;
#(
   parameter int unsigned DATA_W           = 16,
   parameter int unsigned SEL_W            = 5,
   parameter int unsigned FN_W             = 4,
   parameter int unsigned CONST_FN_CODE    = 7,
   parameter bit          CONST_FROM_PARAM = 1'b0,
   parameter logic [(2**(SRC_W+SEL_W))*DATA_W-1:0] CONST_FLAT = '0
) (
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] task_a_data,
   input  logic [DATA_W-1:0] task_b_data,
   input  logic [SRC_W-1:0]  bus_src,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [FN_W-1:0]   fn1,
   input  logic [FN_W-1:0]   fn2,
   output logic [DATA_W-1:0] bus_out
);
   localparam int unsigned ADDR_W = SRC_W + SEL_W;
   localparam logic [DATA_W-1:0] ALL_ONES = '1;

   generate
      if (DATA_W < 1 || SEL_W < 1) begin : g_bad_params
         $error("mc_bus_driver: widths must be non-zero");
      end
   endgenerate

   logic [ADDR_W-1:0] const_addr;
   logic [DATA_W-1:0] const_word;
   logic [DATA_W-1:0] src_word;
   logic [DATA_W-1:0] drv_src;
   logic [DATA_W-1:0] drv_const;
   gate_ctl_t         ctl;

   // source field in the upper bits, register select in the lower bits
   assign const_addr = {bus_src, reg_sel};

   mc_const_store #(
      .DATA_W           (DATA_W),
      .ADDR_W           (ADDR_W),
      .CONST_FROM_PARAM (CONST_FROM_PARAM),
      .CONST_FLAT       (CONST_FLAT)
   ) u_store (
      .addr (const_addr),
      .word (const_word)
   );

   mc_src_select #(
      .DATA_W (DATA_W)
   ) u_select (
      .bus_src     (bus_src),
      .reg_rdata   (reg_rdata),
      .mem_rdata   (mem_rdata),
      .task_a_data (task_a_data),
      .task_b_data (task_b_data),
      .src_word    (src_word)
   );

   mc_gate_ctl #(
      .FN_W          (FN_W),
      .CONST_FN_CODE (CONST_FN_CODE)
   ) u_gate (
      .bus_src (bus_src),
      .fn1     (fn1),
      .fn2     (fn2),
      .ctl     (ctl)
   );

   // each driver releases the bus by going to all ones; the bus ANDs them
   assign drv_src   = ctl.const_only ? ALL_ONES : src_word;
   assign drv_const = ctl.mask_en    ? const_word : ALL_ONES;
   assign bus_out   = drv_src & drv_const;

   // R6 R7
   always_comb begin
      if (fn1 == FN_W'(CONST_FN_CODE) || fn2 == FN_W'(CONST_FN_CODE)) begin
         const_only_chk: assert (bus_out == const_word)
            else $error("constant function did not give the constant alone");
      end
   end

   // R8 R9
   always_comb begin
      if (bus_src >= MASK_SRC_FIRST) begin
         mask_subset_chk: assert ((bus_out & ~const_word) == '0)
            else $error("masked source has bits outside the constant");
      end
   end

   // R3
   always_comb begin
      if (bus_src == SRC_IDLE && fn1 != FN_W'(CONST_FN_CODE) && fn2 != FN_W'(CONST_FN_CODE)) begin
         idle_ones_chk: assert (bus_out == ALL_ONES)
            else $error("idle bus is not all ones");
      end
   end

   // R1
   always_comb begin
      if (bus_src == SRC_REG && fn1 != FN_W'(CONST_FN_CODE) && fn2 != FN_W'(CONST_FN_CODE)) begin
         reg_pass_chk: assert (bus_out == reg_rdata)
            else $error("register source not passed through");
      end
   end

endmodule

// File: tb/mc_bus_driver_tb.sv
module mc_bus_driver_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [15:0] reg_rdata = '0;
   logic [15:0] mem_rdata = '0;
   logic [15:0] task_a_data = '0;
   logic [15:0] task_b_data = '0;
   logic [2:0]  bus_src = '0;
   logic [4:0]  reg_sel = '0;
   logic [3:0]  fn1 = '0;
   logic [3:0]  fn2 = '0;
   logic [15:0] bus_out;

   mc_bus_driver u_dut (
      .reg_rdata   (reg_rdata),
      .mem_rdata   (mem_rdata),
      .task_a_data (task_a_data),
      .task_b_data (task_b_data),
      .bus_src     (bus_src),
      .reg_sel     (reg_sel),
      .fn1         (fn1),
      .fn2         (fn2),
      .bus_out     (bus_out)
   );

   typedef struct {
      logic [15:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // R11 model of the constant store
   function automatic logic [15:0] const_of(input logic [7:0] a);
      return {a, ~a};
   endfunction

   function automatic logic [15:0] model(
      input logic [2:0] s, input logic [4:0] r, input logic [3:0] f1, input logic [3:0] f2,
      input logic [15:0] rd, input logic [15:0] md, input logic [15:0] ta, input logic [15:0] tb);
      logic [15:0] c;
      c = const_of({s, r});                 // R5 address
      if (f1 == 4'd7 || f2 == 4'd7) return c; // R6 R7
      case (s)
         3'd0: return rd;                   // R1
         3'd1: return 16'h0000;             // R2
         3'd2: return 16'hFFFF;             // R3
         3'd3: return ta;                   // R4
         3'd4: return tb;                   // R4
         3'd5: return md & c;               // R8
         default: return c;                 // R9
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] s, input logic [3:0] f1, input logic [3:0] f2);
      if (f1 == 4'd7) return "R6";
      if (f2 == 4'd7) return "R7";
      if (f1 != 4'd0 || f2 != 4'd0) return "R10";
      case (s)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3, 3'd4: return "R4";
         3'd5: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic drive(input logic [2:0] s, input logic [4:0] r, input logic [3:0] f1,
                        input logic [3:0] f2, input logic [15:0] rd, input logic [15:0] md,
                        input logic [15:0] ta, input logic [15:0] tb, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      bus_src = s; reg_sel = r; fn1 = f1; fn2 = f2;
      reg_rdata = rd; mem_rdata = md; task_a_data = ta; task_b_data = tb;
      it.exp = model(s, r, f1, f2, rd, md, ta, tb);
      it.tag = (tag == "") ? tag_of(s, f1, f2) : tag;
      q.push_back(it);
   endtask

   // monitor: result due in the same cycle (R12), compared at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (bus_out !== it.exp) begin
               errors++;
               $display("FAIL %s: bus_out=%h expected=%h (src=%0d sel=%0d fn1=%0d fn2=%0d)",
                        it.tag, bus_out, it.exp, bus_src, reg_sel, fn1, fn2);
            end
         end
      end
   end

   initial begin
      logic [3:0] f1s [6] = '{4'd0, 4'd7, 4'd0, 4'd7, 4'd3, 4'd0};
      logic [3:0] f2s [6] = '{4'd0, 4'd0, 4'd7, 4'd7, 4'd0, 4'd12};
      logic [15:0] seed;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R12 initial settled state: register source with zero data gives zero
      drive(3'd0, 5'd0, 4'd0, 4'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, "R12");
      // R11 R5 spot checks through the constant function
      drive(3'd0, 5'd0, 4'd7, 4'd0, 16'h1234, 16'h0, 16'h0, 16'h0, "R11");
      drive(3'd7, 5'd31, 4'd0, 4'd7, 16'h1234, 16'h0, 16'h0, 16'h0, "R11");
      drive(3'd2, 5'd5, 4'd7, 4'd7, 16'h0, 16'h0, 16'h0, 16'h0, "R5");
      // R8 memory all ones gives the mask itself; all zeros gives zero
      drive(3'd5, 5'd9, 4'd0, 4'd0, 16'h0, 16'hFFFF, 16'h0, 16'h0, "R8");
      drive(3'd5, 5'd9, 4'd0, 4'd0, 16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFF, "R8");
      // R10 function codes near 7 leave a plain source untouched
      drive(3'd3, 5'd1, 4'd6, 4'd8, 16'h0, 16'h0, 16'hBEEF, 16'h0, "R10");
      drive(3'd4, 5'd2, 4'd15, 4'd15, 16'h0, 16'h0, 16'h0, 16'hCAFE, "R10");
      // full sweep of sources, selects and function combinations
      seed = 16'hA5C3;
      for (int s = 0; s < 8; s++) begin
         for (int r = 0; r < 32; r++) begin
            for (int k = 0; k < 6; k++) begin
               seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
               drive(3'(s), 5'(r), f1s[k], f2s[k], seed, ~seed, seed ^ 16'h0F0F,
                     {seed[7:0], seed[15:8]}, "");
            end
         end
      end
      @(posedge clk);
      @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule